// File: doc/BRIEF.md
# Pulse Period and Width Measurement Timer

This block measures a periodic square wave on its own, with no processor time spent on it. Each input cycle runs from one rising edge to the next. For each cycle the block reports two values, both counted in ticks of a reference time base. The first is the time the signal stays high. The second is the full period. The time base is a one-cycle enable (`ref_tick`) on the block clock, so the counting rate does not depend on the rate of the processor.

The asynchronous input passes through a synchronizer and an edge detector. A saturating counter restarts on every accepted rising edge. Its value is captured on the falling edge (high time) and on the next rising edge (period). The finished pair goes into a set of published registers in a single step. Those registers do not change again until the next result, so software has a whole input period to read them. A completion flag and a one-cycle interrupt pulse announce each new result, and software clears the flag by pulsing `flag_clr`. In averaging mode the block sums a window of 2^`cfg_avg_shift` cycles and publishes their mean, with one completion per window.

The control state machine has four states. `ST_IDLE` means disabled. `ST_ARM` waits for the first rising edge. `ST_HIGH` counts the high phase and `ST_LOW` counts the low phase. The transitions are:
- enable: `ST_IDLE`→`ST_ARM`
- first rise: `ST_ARM`→`ST_HIGH`
- fall: `ST_HIGH`→`ST_LOW`
- period rise: `ST_LOW`→`ST_HIGH`
- disable: any state→`ST_IDLE`, taken whenever `cfg_enable` is low.

Top module: `pulse_meter`

## Requirements
- R1: After reset, every output is 0: `width_q`, `period_q`, `result_valid`, `done_flag`, `irq`, `busy` and `overflow`.
- R2: With `ref_tick` held high, an input that is high for H clocks and then low for L clocks is published as `width_q`=H and `period_q`=H+L. A rising edge restarts the counter, a falling edge captures the width, and the next rising edge captures the period.
- R3: After enable, the first rising edge only arms the block. No completion is reported until one whole input period has been measured.
- R4: Each publish sets `done_flag` and pulses `irq` high for exactly one clock. A one-clock pulse on `flag_clr` clears `done_flag` and also clears the overflow status (R8). The published values stay as they are.
- R5: `busy` is 1 while the block is enabled and no unread result is flagged. It is 0 when the block is disabled or when `done_flag` is set.
- R6: `width_q`, `period_q` and `result_valid` change only at a publish. A falling edge during the following cycle leaves them untouched.
- R7: Both the counter and the edge evaluation advance only on clocks where `ref_tick` is 1. With `ref_tick` alternating, an input of 6 high and 10 low clocks gives a width of 3 and a period of 8.
- R8: The counter stops at its all-ones value, 2^CNT_W−1 (CNT_W defaults to 24). Once it saturates, `overflow` is set and stays set until `flag_clr`. The result of that measurement is published with the saturated counts and with `result_valid`=0.
- R9: When `cfg_avg_en`=1, completions occur once per window of 2^`cfg_avg_shift` periods. The published values are floor(sum/2^shift) of the widths and of the periods in that window.
- R10: While `cfg_enable`=0, input edges produce no completion. `busy` stays 0 and the published values are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_tick | input | 1 | Reference time-base enable, one clock per count |
| sig_in | input | 1 | Asynchronous square-wave input |
| cfg_enable | input | 1 | Measurement enable |
| cfg_avg_en | input | 1 | Averaging mode select |
| cfg_avg_shift | input | AVG_SH_W | log2 of the averaging window length |
| flag_clr | input | 1 | Clears the completion flag and the overflow status |
| width_q | output | CNT_W | Published high time |
| period_q | output | CNT_W | Published period |
| result_valid | output | 1 | Published result had no saturation |
| done_flag | output | 1 | New result available |
| irq | output | 1 | One-clock completion pulse |
| busy | output | 1 | Acquisition in progress |
| overflow | output | 1 | Counter saturated since last clear |

## Verification
A state machine stuck in or skipping a state would show up within the first measured period. Either no completion appears after the second rising edge, or `irq` fires early, before a full period has been seen. A counter clear placed on the wrong edge, or a width register that is not shadowed, would change `width_q` or `period_q` by a fixed offset, or would change them in the middle of a period. The bench reads back exact counts for widths as small as one tick, and for stretched ticks. A saturation flag that is lost or never cleared would show in `result_valid` and `overflow` on the next publish.

// File: rtl/pm_pkg.sv
package pm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARM,
        ST_HIGH,
        ST_LOW
    } pm_state_e;
endpackage

// File: rtl/pm_sync_edge.sv
module pm_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sig_async,
    output logic rise,
    output logic fall
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;
    logic                   level;

    assign level = chain_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[SYNC_STAGES-2:0], sig_async};
            if (tick) prev_q <= level;
        end
    end

    assign rise = tick &  level & ~prev_q;
    assign fall = tick & ~level &  prev_q;

    // an accepted rising edge is consumed: it cannot repeat on the next clock
    assert_single_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/pm_counter.sv
module pm_counter #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         clr,
    output logic [W-1:0] cnt,
    output logic         sat
);
    localparam logic [W-1:0] MAXV = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      cnt <= '0;
        else if (clr)                    cnt <= '0;
        else if (tick && (cnt != MAXV))  cnt <= cnt + 1'b1;
    end

    assign sat = tick & ~clr & (cnt == MAXV);

    assert_cnt_holds_max_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr && cnt == MAXV) |=> (cnt == MAXV));
endmodule

// File: rtl/pm_result.sv
module pm_result #(
    parameter int W    = 24,
    parameter int SH_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic            capture,
    input  logic [W-1:0]    w_in,
    input  logic [W-1:0]    p_in,
    input  logic            bad_in,
    input  logic            avg_en,
    input  logic [SH_W-1:0] avg_shift,
    output logic            pub,
    output logic [W-1:0]    width_q,
    output logic [W-1:0]    period_q,
    output logic            valid_q
);
    localparam int SMAX = (1 << SH_W) - 1;
    localparam int AW   = W + SMAX;

    logic [AW-1:0]   acc_w_q, acc_p_q, sum_w, sum_p;
    logic [SMAX-1:0] win_q, win_goal;
    logic [SH_W-1:0] eff_sh;
    logic            bad_acc_q, win_last;

    assign eff_sh   = avg_en ? avg_shift : '0;
    assign win_goal = SMAX'((32'd1 << avg_shift) - 32'd1);
    assign win_last = !avg_en || (win_q == win_goal);
    assign sum_w    = acc_w_q + AW'(w_in);
    assign sum_p    = acc_p_q + AW'(p_in);
    assign pub      = capture & win_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_w_q   <= '0;
            acc_p_q   <= '0;
            win_q     <= '0;
            bad_acc_q <= 1'b0;
            width_q   <= '0;
            period_q  <= '0;
            valid_q   <= 1'b0;
        end else if (restart) begin
            acc_w_q   <= '0;
            acc_p_q   <= '0;
            win_q     <= '0;
            bad_acc_q <= 1'b0;
        end else if (capture) begin
            if (win_last) begin
                width_q   <= W'(sum_w >> eff_sh);
                period_q  <= W'(sum_p >> eff_sh);
                valid_q   <= ~(bad_acc_q | bad_in);
                acc_w_q   <= '0;
                acc_p_q   <= '0;
                win_q     <= '0;
                bad_acc_q <= 1'b0;
            end else begin
                acc_w_q   <= sum_w;
                acc_p_q   <= sum_p;
                win_q     <= win_q + 1'b1;
                bad_acc_q <= bad_acc_q | bad_in;
            end
        end
    end

    assert_hold_results_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pub |=> ($stable(width_q) && $stable(period_q) && $stable(valid_q)));
endmodule

// File: rtl/pulse_meter.sv
module pulse_meter
    import pm_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int AVG_SH_W    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ref_tick,
    input  logic                sig_in,
    input  logic                cfg_enable,
    input  logic                cfg_avg_en,
    input  logic [AVG_SH_W-1:0] cfg_avg_shift,
    input  logic                flag_clr,
    output logic [CNT_W-1:0]    width_q,
    output logic [CNT_W-1:0]    period_q,
    output logic                result_valid,
    output logic                done_flag,
    output logic                irq,
    output logic                busy,
    output logic                overflow
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    pm_state_e        state_q, state_d;
    logic             rise, fall, cnt_clr, cnt_sat, at_max;
    logic             capture, fall_cap, pub, bad_meas_q, bad_now;
    logic [CNT_W-1:0] cnt, cap_val, w_shadow_q;

    pm_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .tick(ref_tick), .sig_async(sig_in),
        .rise(rise), .fall(fall)
    );

    assign cnt_clr = rise | (state_q == ST_IDLE) | (state_q == ST_ARM);

    pm_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(ref_tick), .clr(cnt_clr),
        .cnt(cnt), .sat(cnt_sat)
    );

    assign at_max   = (cnt == CNT_MAX);
    assign cap_val  = at_max ? cnt : cnt + 1'b1;
    assign capture  = cfg_enable & (state_q == ST_LOW)  & rise;
    assign fall_cap = cfg_enable & (state_q == ST_HIGH) & fall;
    assign bad_now  = bad_meas_q | at_max;

    pm_result #(.W(CNT_W), .SH_W(AVG_SH_W)) u_res (
        .clk(clk), .rst_n(rst_n), .restart(state_q == ST_IDLE),
        .capture(capture), .w_in(w_shadow_q), .p_in(cap_val), .bad_in(bad_now),
        .avg_en(cfg_avg_en), .avg_shift(cfg_avg_shift), .pub(pub),
        .width_q(width_q), .period_q(period_q), .valid_q(result_valid)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!cfg_enable) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_ARM;
                ST_ARM:  if (rise) state_d = ST_HIGH;
                ST_HIGH: if (fall) state_d = ST_LOW;
                ST_LOW:  if (rise) state_d = ST_HIGH;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs and measurement bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_shadow_q <= '0;
            bad_meas_q <= 1'b0;
            done_flag  <= 1'b0;
            irq        <= 1'b0;
            overflow   <= 1'b0;
        end else begin
            if (fall_cap) w_shadow_q <= cap_val;

            if ((state_q == ST_IDLE) || (state_q == ST_ARM) || capture)
                bad_meas_q <= 1'b0;
            else if (cnt_sat || (fall_cap && at_max))
                bad_meas_q <= 1'b1;

            irq <= pub;
            if (pub)           done_flag <= 1'b1;
            else if (flag_clr) done_flag <= 1'b0;

            if (cnt_sat)       overflow <= 1'b1;
            else if (flag_clr) overflow <= 1'b0;
        end
    end

    assign busy = (state_q != ST_IDLE) & ~done_flag;

    assert_fall_to_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HIGH && fall && cfg_enable) |=> (state_q == ST_LOW));
    assert_irq_from_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(state_q) == ST_LOW));
    assert_irq_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done_flag);
    assert_ovf_from_max_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(cnt == CNT_MAX));
    assert_disable_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> (state_q == ST_IDLE));
endmodule

// File: tb/pulse_meter_bench.sv
module pulse_meter_bench;
    localparam int CW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_tick = 1'b1;
    logic          ref_div = 1'b0;
    logic          sig_in = 1'b0;
    logic          cfg_enable = 1'b0;
    logic          cfg_avg_en = 1'b0;
    logic [1:0]    cfg_avg_shift = '0;
    logic          flag_clr = 1'b0;
    logic [CW-1:0] width_q, period_q;
    logic          result_valid, done_flag, irq, busy, overflow;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    always @(negedge clk) ref_tick <= ref_div ? ~ref_tick : 1'b1;

    pulse_meter #(.CNT_W(CW), .AVG_SH_W(2), .SYNC_STAGES(2)) u_pulse_meter (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .sig_in(sig_in),
        .cfg_enable(cfg_enable), .cfg_avg_en(cfg_avg_en),
        .cfg_avg_shift(cfg_avg_shift), .flag_clr(flag_clr),
        .width_q(width_q), .period_q(period_q), .result_valid(result_valid),
        .done_flag(done_flag), .irq(irq), .busy(busy), .overflow(overflow)
    );

    // high, low, shift, avg, expected width, expected period
    localparam int NV = 6;
    localparam int VEC [NV][6] = '{
        '{3, 5, 0, 0, 3, 8},
        '{10, 2, 0, 0, 10, 12},
        '{1, 1, 0, 0, 1, 2},
        '{7, 9, 1, 1, 7, 16},
        '{4, 4, 2, 1, 4, 8},
        '{20, 13, 3, 1, 20, 33}
    };

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clr();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic start(bit avg, int sh);
        cfg_enable = 1'b0;
        cfg_avg_en = avg;
        cfg_avg_shift = 2'(sh);
        sig_in = 1'b0;
        cyc(2);
        pulse_clr();
        cfg_enable = 1'b1;
        cyc(4);
    endtask

    task automatic one_period(int h, int l);
        sig_in = 1'b1;
        cyc(h);
        sig_in = 1'b0;
        cyc(l);
    endtask

    task automatic final_rise(output int irqs);
        irqs = 0;
        sig_in = 1'b1;
        repeat (6) begin
            @(negedge clk);
            irqs += int'(irq);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int irqs;
        cyc(3);
        // R1 reset state
        chk("R1 width", int'(width_q), 0);
        chk("R1 period", int'(period_q), 0);
        chk("R1 valid", int'(result_valid), 0);
        chk("R1 done", int'(done_flag), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 ovf", int'(overflow), 0);
        rst_n = 1'b1;
        cyc(2);

        // R2/R3/R4/R9 table walk
        for (int v = 0; v < NV; v++) begin
            start(VEC[v][3] != 0, VEC[v][2]);
            for (int i = 0; i < (1 << VEC[v][2]); i++) one_period(VEC[v][0], VEC[v][1]);
            chk("R3 R9 no early done", int'(done_flag), 0);
            final_rise(irqs);
            chk("R4 single irq", irqs, 1);
            chk("R4 done", int'(done_flag), 1);
            chk("R2 R9 width", int'(width_q), VEC[v][4]);
            chk("R2 R9 period", int'(period_q), VEC[v][5]);
            chk("R2 valid", int'(result_valid), 1);
        end

        // R3 first rise only arms; R5 busy
        start(1'b0, 0);
        chk("R5 busy enabled", int'(busy), 1);
        one_period(5, 5);
        chk("R3 armed no done", int'(done_flag), 0);
        final_rise(irqs);
        chk("R2 width 5", int'(width_q), 5);
        chk("R2 period 10", int'(period_q), 10);
        chk("R5 busy after done", int'(busy), 0);
        // R6 double buffer: width 9, low 6; old values held mid-cycle
        cyc(3);
        sig_in = 1'b0;
        pulse_clr();
        chk("R4 clr done", int'(done_flag), 0);
        chk("R4 clr keeps width", int'(width_q), 5);
        chk("R5 busy after clr", int'(busy), 1);
        cyc(5);
        chk("R6 width held", int'(width_q), 5);
        chk("R6 period held", int'(period_q), 10);
        final_rise(irqs);
        chk("R6 new width", int'(width_q), 9);
        chk("R6 new period", int'(period_q), 15);

        // R9 mixed window of two periods
        start(1'b1, 1);
        one_period(4, 6);
        one_period(7, 6);
        chk("R9 one per window", int'(done_flag), 0);
        final_rise(irqs);
        chk("R9 avg width", int'(width_q), 5);
        chk("R9 avg period", int'(period_q), 11);
        chk("R9 irq count", irqs, 1);

        // R7 alternating reference tick
        ref_div = 1'b1;
        start(1'b0, 0);
        one_period(6, 10);
        final_rise(irqs);
        chk("R7 width", int'(width_q), 3);
        chk("R7 period", int'(period_q), 8);
        ref_div = 1'b0;
        cyc(2);

        // R8 saturation
        start(1'b0, 0);
        sig_in = 1'b1;
        cyc(4200);
        chk("R8 ovf set", int'(overflow), 1);
        cyc(800);
        sig_in = 1'b0;
        cyc(10);
        final_rise(irqs);
        chk("R8 width sat", int'(width_q), 4095);
        chk("R8 period sat", int'(period_q), 4095);
        chk("R8 invalid", int'(result_valid), 0);
        chk("R8 ovf sticky", int'(overflow), 1);
        pulse_clr();
        chk("R8 ovf clr", int'(overflow), 0);
        sig_in = 1'b0;
        cyc(3);
        final_rise(irqs);
        chk("R8 next width", int'(width_q), 7);
        chk("R8 next period", int'(period_q), 10);
        chk("R8 next valid", int'(result_valid), 1);

        // R10 disabled: edges ignored, results held
        start(1'b0, 0);
        one_period(4, 4);
        final_rise(irqs);
        chk("R10 pre width", int'(width_q), 4);
        pulse_clr();
        cfg_enable = 1'b0;
        sig_in = 1'b0;
        cyc(3);
        one_period(3, 3);
        one_period(3, 3);
        final_rise(irqs);
        chk("R10 no irq", irqs, 0);
        chk("R10 no done", int'(done_flag), 0);
        chk("R10 busy", int'(busy), 0);
        chk("R10 width held", int'(width_q), 4);
        chk("R10 period held", int'(period_q), 8);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule